// File: doc/BRIEF.md
# Fault and Sleep Supervisor

This block sits between the analog protection comparators of a dual H-bridge motor driver and the enables of its power resources. It decides, on every clock, whether each bridge may drive, whether the charge pump and the low-voltage regulator run, and whether the open-drain fault flag is pulled low. Its inputs are a run request (low means sleep), a supply undervoltage flag, a charge-pump undervoltage flag, an over-temperature flag, per-FET current-limit flags and a sense-overvoltage flag for each bridge. All of these arrive asynchronously and are synchronized before use.

Each fault class switches off its own set of resources. Supply undervoltage also stops the charge pump. Charge-pump undervoltage and over-temperature stop only the bridges. Overcurrent is detected per bridge, either from a current-limit flag that stays up longer than a persistence window or at once from a sense-overvoltage flag. It starts a retry interval, after which the bridge is tried again. A static variant input chooses whether an overcurrent stops both bridges (phase/enable variant) or only the faulting one (PWM variant). Sleep entry is delayed by a drain interval, and wake-up holds the bridges off for a settling interval. All intervals are parameters counted in clock ticks. None of the pins carries a data stream, so the block has no handshakes.

Top module: `fault_sleep_supervisor`

## Requirements
- R1: While reset is applied, and after reset with `run_req` low, `bridge_en`, `pump_en` and `ldo_en` are all 0 and `fault_n` is 1.
- R2: Three clocks after `run_req` rises, `ldo_en` and `pump_en` go to 1. `bridge_en` stays 0 for a further `T_WAKE` clocks and then goes to all ones if no fault is present.
- R3: After `run_req` falls, every enable stays as it was for `T_SLEEP`+2 clocks and is then 0. While asleep, `fault_n` is 1 and every fault input is ignored.
- R4: Supply undervoltage clears `bridge_en` and `pump_en` and drives `fault_n` low, while `ldo_en` stays 1. All of these are restored when the flag drops.
- R5: Charge-pump undervoltage clears `bridge_en` and drives `fault_n` low, while `pump_en` and `ldo_en` stay 1. Operation resumes when the flag drops.
- R6: Over-temperature clears `bridge_en` and drives `fault_n` low, while `pump_en` and `ldo_en` stay 1. Operation resumes when the flag drops.
- R7: A current-limit flag of bridge b (bits b*NF to b*NF+NF-1 of `fet_limit`, ORed together) that is high for `T_OCP` synchronized clocks or fewer has no effect. If it is high for `T_OCP`+1 consecutive clocks, an overcurrent trip occurs and the bridge is off from the next clock.
- R8: A sense-overvoltage flag on bit b of `sense_ov` trips bridge b on its first synchronized clock.
- R9: After a trip the bridge stays off, with `fault_n` low, for `T_RETRY` clocks. It is then re-enabled and `fault_n` is released. A fault that is still present trips it again.
- R10: With `ocp_gang` = 1, an overcurrent trip on any bridge clears every bit of `bridge_en`.
- R11: With `ocp_gang` = 0, only the tripped bridge is cleared and the other keeps driving.
- R12: Every asynchronous input passes through two flip-flops. A level change on a fault input reaches the outputs on the second clock edge after it, and never on the first.
- R13: When several faults are present at once, each enable is the AND of the masks of the individual faults, and `fault_n` stays low until the last of them clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_req | input | 1 | Asynchronous; 1 = operate, 0 = sleep |
| supply_uv | input | 1 | Asynchronous supply undervoltage flag |
| pump_uv | input | 1 | Asynchronous charge-pump undervoltage flag |
| over_temp | input | 1 | Asynchronous over-temperature flag |
| fet_limit | input | NB*NF | Asynchronous per-FET current-limit flags; bridge b owns bits b*NF+NF-1 down to b*NF |
| sense_ov | input | NB | Asynchronous sense-overvoltage flag per bridge |
| ocp_gang | input | 1 | Static variant: 1 = overcurrent stops all bridges, 0 = only the faulting bridge |
| bridge_en | output | NB | Drive permission per bridge |
| pump_en | output | 1 | Charge pump enable |
| ldo_en | output | 1 | Regulator enable |
| fault_n | output | 1 | Fault flag, active low (drives an open-drain pad) |

## Verification
The bound checker watches invariants on every cycle. Supply undervoltage always leaves the pump and bridges off. A sleeping block has every output quiet. No bridge drives without the pump. Over-temperature and pump undervoltage never stop the pump. In the ganged variant the bridges never split. Bridges never start in the same cycle as the regulator. Exact timings cannot be seen from a single cycle: the persistence window, the retry length and its repeat, the drain and settling delays, and the two-stage synchronizer latency. The bench's scenarios show these, compared against a behavioural model on every clock.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  typedef enum logic [1:0] {
    PW_ASLEEP = 2'd0,
    PW_WAKING = 2'd1,
    PW_ACTIVE = 2'd2,
    PW_DRAIN  = 2'd3
  } pwr_state_t;
endpackage

// File: rtl/fsup_sync.sv
module fsup_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fsup_pwr_seq.sv
module fsup_pwr_seq
  import fsup_pkg::*;
#(
  parameter int T_SLEEP = 10000,
  parameter int T_WAKE  = 15000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  output pwr_state_t state
);
  localparam int TMAX = (T_SLEEP > T_WAKE) ? T_SLEEP : T_WAKE;
  localparam int CW   = $clog2(TMAX + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= PW_ASLEEP;
      cnt   <= '0;
    end else begin
      unique case (state)
        PW_ASLEEP: if (req) begin
          state <= PW_WAKING;
          cnt   <= '0;
        end
        PW_WAKING: begin
          if (!req) state <= PW_ASLEEP;
          else if (cnt == CW'(T_WAKE - 1)) state <= PW_ACTIVE;
          else cnt <= cnt + CW'(1);
        end
        PW_ACTIVE: if (!req) begin
          state <= PW_DRAIN;
          cnt   <= '0;
        end
        PW_DRAIN: begin
          if (req) state <= PW_ACTIVE;
          else if (cnt == CW'(T_SLEEP - 1)) state <= PW_ASLEEP;
          else cnt <= cnt + CW'(1);
        end
        default: state <= PW_ASLEEP;
      endcase
    end
  end
endmodule

// File: rtl/fsup_ocp_chan.sv
module fsup_ocp_chan #(
  parameter int NF      = 4,
  parameter int T_OCP   = 30,
  parameter int T_RETRY = 16000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          arm,
  input  logic [NF-1:0] lim,
  input  logic          sense,
  output logic          off
);
  localparam int PW = $clog2(T_OCP + 1);
  localparam int RW = $clog2(T_RETRY + 1);

  logic [PW-1:0] pcnt;
  logic [RW-1:0] rcnt;
  logic          any_lim;

  assign any_lim = |lim;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      off  <= 1'b0;
      pcnt <= '0;
      rcnt <= '0;
    end else if (off) begin
      pcnt <= '0;
      if (rcnt == RW'(T_RETRY - 1)) begin
        off  <= 1'b0;
        rcnt <= '0;
      end else begin
        rcnt <= rcnt + RW'(1);
      end
    end else if (arm && (sense || (any_lim && pcnt == PW'(T_OCP)))) begin
      off  <= 1'b1;
      rcnt <= '0;
      pcnt <= '0;
    end else if (arm && any_lim) begin
      pcnt <= pcnt + PW'(1);
    end else begin
      pcnt <= '0;
    end
  end
endmodule

// File: rtl/fault_sleep_supervisor.sv
module fault_sleep_supervisor
  import fsup_pkg::*;
#(
  parameter int NB      = 2,
  parameter int NF      = 4,
  parameter int T_OCP   = 30,
  parameter int T_RETRY = 16000,
  parameter int T_SLEEP = 10000,
  parameter int T_WAKE  = 15000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_req,
  input  logic             supply_uv,
  input  logic             pump_uv,
  input  logic             over_temp,
  input  logic [NB*NF-1:0] fet_limit,
  input  logic [NB-1:0]    sense_ov,
  input  logic             ocp_gang,
  output logic [NB-1:0]    bridge_en,
  output logic             pump_en,
  output logic             ldo_en,
  output logic             fault_n
);
  localparam int SW = 4 + NB * NF + NB;

  logic [SW-1:0]    raw, syn;
  logic             req_q, uv_q, cp_q, ot_q;
  logic [NB*NF-1:0] lim_q;
  logic [NB-1:0]    sov_q, trip;
  pwr_state_t       pstate;
  logic             awake, run, any_trip;

  assign raw = {run_req, supply_uv, pump_uv, over_temp, fet_limit, sense_ov};

  fsup_sync #(.W(SW)) u_sync (.clk(clk), .rst_n(rst_n), .d(raw), .q(syn));

  assign {req_q, uv_q, cp_q, ot_q, lim_q, sov_q} = syn;

  fsup_pwr_seq #(.T_SLEEP(T_SLEEP), .T_WAKE(T_WAKE)) u_seq (
    .clk(clk), .rst_n(rst_n), .req(req_q), .state(pstate)
  );

  assign awake = (pstate != PW_ASLEEP);
  assign run   = (pstate == PW_ACTIVE || pstate == PW_DRAIN) && !uv_q && !cp_q && !ot_q;

  for (genvar b = 0; b < NB; b++) begin : g_br
    fsup_ocp_chan #(.NF(NF), .T_OCP(T_OCP), .T_RETRY(T_RETRY)) u_ocp (
      .clk(clk), .rst_n(rst_n), .clr(!awake), .arm(run),
      .lim(lim_q[b*NF +: NF]), .sense(sov_q[b]), .off(trip[b])
    );
    assign bridge_en[b] = run && !trip[b] && !(ocp_gang && any_trip);
  end

  assign any_trip = |trip;
  assign ldo_en   = awake;
  assign pump_en  = awake && !uv_q;
  assign fault_n  = !(awake && (uv_q || cp_q || ot_q || any_trip));
endmodule

// File: rtl/fsup_chk.sv
module fsup_chk #(
  parameter int NB = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          uv_q,
  input logic          cp_q,
  input logic          ot_q,
  input logic          ocp_gang,
  input logic [NB-1:0] bridge_en,
  input logic          pump_en,
  input logic          ldo_en,
  input logic          fault_n
);
  p_uv_stops_pump_r4: assert property (@(posedge clk) disable iff (!rst_n)
    uv_q |-> (!pump_en && bridge_en == '0));

  p_asleep_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ldo_en |-> (!pump_en && bridge_en == '0 && fault_n));

  p_bridge_needs_pump_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|bridge_en) |-> pump_en);

  p_cp_keeps_pump_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_q && !uv_q && ldo_en) |-> (pump_en && bridge_en == '0 && !fault_n));

  p_ot_keeps_pump_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_q && !uv_q && ldo_en) |-> (pump_en && bridge_en == '0 && !fault_n));

  p_gang_no_split_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_gang |-> (bridge_en == '0 || bridge_en == '1));

  p_wake_settle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|bridge_en) |-> $past(ldo_en));
endmodule

bind fault_sleep_supervisor fsup_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .uv_q(uv_q), .cp_q(cp_q), .ot_q(ot_q),
  .ocp_gang(ocp_gang), .bridge_en(bridge_en), .pump_en(pump_en),
  .ldo_en(ldo_en), .fault_n(fault_n)
);

// File: tb/tb_fault_sleep_supervisor.sv
`timescale 1ns/1ps
module tb_fault_sleep_supervisor;
  localparam int NB = 2, NF = 4;
  localparam int TO = 3, TR = 12, TS = 10, TW = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic run_req = 0, supply_uv = 0, pump_uv = 0, over_temp = 0, ocp_gang = 0;
  logic [NB*NF-1:0] fet_limit = '0;
  logic [NB-1:0] sense_ov = '0;
  logic [NB-1:0] bridge_en;
  logic pump_en, ldo_en, fault_n;

  int checks = 0, fails = 0;
  bit model_on = 0;

  always #4 clk = ~clk;

  fault_sleep_supervisor #(.NB(NB), .NF(NF), .T_OCP(TO), .T_RETRY(TR),
    .T_SLEEP(TS), .T_WAKE(TW)) dut (
    .clk(clk), .rst_n(rst_n), .run_req(run_req), .supply_uv(supply_uv),
    .pump_uv(pump_uv), .over_temp(over_temp), .fet_limit(fet_limit),
    .sense_ov(sense_ov), .ocp_gang(ocp_gang), .bridge_en(bridge_en),
    .pump_en(pump_en), .ldo_en(ldo_en), .fault_n(fault_n));

  // behavioural reference: two-deep input history, mode integer, counters
  int m_req [2], m_uv [2], m_cp [2], m_ot [2];
  int m_lim [2][NB], m_sov [2][NB];
  int mode = 0, tmr = 0;
  int pers [NB], left [NB];

  always @(posedge clk) begin
    if (!rst_n) begin
      mode = 0; tmr = 0;
      for (int i = 0; i < 2; i++) begin
        m_req[i] = 0; m_uv[i] = 0; m_cp[i] = 0; m_ot[i] = 0;
        for (int b = 0; b < NB; b++) begin m_lim[i][b] = 0; m_sov[i][b] = 0; end
      end
      for (int b = 0; b < NB; b++) begin pers[b] = 0; left[b] = 0; end
    end else begin
      automatic bit drive = (mode == 2 || mode == 3) && !m_uv[1] && !m_cp[1] && !m_ot[1];
      for (int b = 0; b < NB; b++) begin
        if (mode == 0) begin pers[b] = 0; left[b] = 0; end
        else if (left[b] > 0) begin left[b]--; pers[b] = 0; end
        else if (drive && (m_sov[1][b] != 0 || (m_lim[1][b] != 0 && pers[b] + 1 > TO)))
          begin left[b] = TR; pers[b] = 0; end
        else if (drive && m_lim[1][b] != 0) pers[b]++;
        else pers[b] = 0;
      end
      case (mode)
        0: if (m_req[1] != 0) begin mode = 1; tmr = TW; end
        1: if (m_req[1] == 0) mode = 0; else begin tmr--; if (tmr == 0) mode = 2; end
        2: if (m_req[1] == 0) begin mode = 3; tmr = TS; end
        default: if (m_req[1] != 0) mode = 2; else begin tmr--; if (tmr == 0) mode = 0; end
      endcase
      m_req[1] = m_req[0]; m_uv[1] = m_uv[0]; m_cp[1] = m_cp[0]; m_ot[1] = m_ot[0];
      for (int b = 0; b < NB; b++) begin
        m_lim[1][b] = m_lim[0][b]; m_sov[1][b] = m_sov[0][b];
        m_lim[0][b] = |fet_limit[b*NF +: NF]; m_sov[0][b] = sense_ov[b];
      end
      m_req[0] = run_req; m_uv[0] = supply_uv; m_cp[0] = pump_uv; m_ot[0] = over_temp;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model (R12 latency included)
  always @(negedge clk) if (model_on) begin
    automatic int awake = (mode != 0);
    automatic int drive = (mode == 2 || mode == 3) && !m_uv[1] && !m_cp[1] && !m_ot[1];
    automatic int anyt = 0;
    automatic int eb = 0;
    for (int b = 0; b < NB; b++) if (left[b] > 0) anyt = 1;
    for (int b = 0; b < NB; b++)
      if (drive && left[b] == 0 && !(ocp_gang && anyt)) eb |= (1 << b);
    chk("R12 model bridge_en", int'(bridge_en), eb);
    chk("R12 model pump_en", int'(pump_en), awake && !m_uv[1]);
    chk("R12 model ldo_en", int'(ldo_en), awake);
    chk("R12 model fault_n", int'(fault_n), !(awake && (m_uv[1] || m_cp[1] || m_ot[1] || anyt)));
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    step(3);
    chk("R1 reset bridge_en", int'(bridge_en), 0);
    chk("R1 reset ldo_en", int'(ldo_en), 0);
    chk("R1 reset fault_n", int'(fault_n), 1);
    rst_n = 1; model_on = 1;
    step(5);
    chk("R1 idle pump_en", int'(pump_en), 0);

    // R2 wake
    run_req = 1;
    step(2); chk("R2 ldo not yet", int'(ldo_en), 0);
    step(1); chk("R2 ldo on", int'(ldo_en), 1); chk("R2 pump on", int'(pump_en), 1);
    step(TW - 1); chk("R2 bridges held", int'(bridge_en), 0);
    step(1); chk("R2 bridges on", int'(bridge_en), 3);

    // R4 supply undervoltage, R12 latency
    supply_uv = 1;
    step(1); chk("R12 no effect after one edge", int'(pump_en), 1);
    step(1); chk("R4 pump off", int'(pump_en), 0); chk("R4 bridges off", int'(bridge_en), 0);
    chk("R4 ldo kept", int'(ldo_en), 1); chk("R4 fault low", int'(fault_n), 0);
    supply_uv = 0; step(2);
    chk("R4 restored", int'(bridge_en), 3); chk("R4 fault released", int'(fault_n), 1);

    // R5 pump undervoltage
    pump_uv = 1; step(2);
    chk("R5 bridges off", int'(bridge_en), 0); chk("R5 pump kept", int'(pump_en), 1);
    chk("R5 fault low", int'(fault_n), 0);
    pump_uv = 0; step(2); chk("R5 resume", int'(bridge_en), 3);

    // R6 over-temperature, R13 combined with pump undervoltage
    over_temp = 1; step(2);
    chk("R6 bridges off", int'(bridge_en), 0); chk("R6 pump kept", int'(pump_en), 1);
    pump_uv = 1; step(3); over_temp = 0; step(2);
    chk("R13 still faulted", int'(fault_n), 0); chk("R13 bridges off", int'(bridge_en), 0);
    pump_uv = 0; step(2);
    chk("R13 released", int'(fault_n), 1); chk("R6 resume", int'(bridge_en), 3);

    // R7 short current-limit pulse ignored
    ocp_gang = 0;
    fet_limit[2] = 1; step(TO); fet_limit[2] = 0;
    step(6); chk("R7 short pulse ignored", int'(bridge_en), 3);
    chk("R7 short pulse no fault", int'(fault_n), 1);

    // R7 persistent limit on bridge 0, R11 split, R9 retry
    fet_limit[1] = 1;
    step(2 + TO); chk("R7 before window", int'(bridge_en), 3);
    step(1); chk("R7 tripped", int'(bridge_en[0]), 0);
    chk("R11 other bridge kept", int'(bridge_en[1]), 1);
    fet_limit[1] = 0;
    step(TR - 1); chk("R9 still off", int'(bridge_en[0]), 0); chk("R9 fault held", int'(fault_n), 0);
    step(1); chk("R9 re-enabled", int'(bridge_en), 3); chk("R9 fault released", int'(fault_n), 1);

    // R8 sense overvoltage, R10 gang, R9 repeat
    step(4); ocp_gang = 1;
    sense_ov[1] = 1;
    step(2); chk("R8 not before sync", int'(bridge_en), 3);
    step(1); chk("R8 immediate trip", int'(bridge_en[1]), 0);
    chk("R10 both off", int'(bridge_en), 0);
    step(TR); chk("R9 retry window ends", int'(bridge_en), 3);
    step(1); chk("R9 repeat trip", int'(bridge_en), 0);
    sense_ov[1] = 0; step(TR + 4);
    chk("R9 recovered", int'(bridge_en), 3);

    // R3 sleep entry and ignored faults while asleep
    run_req = 0;
    step(2 + TS); chk("R3 still on during drain", int'(bridge_en), 3);
    chk("R3 ldo during drain", int'(ldo_en), 1);
    step(1); chk("R3 asleep ldo", int'(ldo_en), 0); chk("R3 asleep bridges", int'(bridge_en), 0);
    chk("R3 asleep pump", int'(pump_en), 0);
    over_temp = 1; supply_uv = 1; step(4);
    chk("R3 faults ignored asleep", int'(fault_n), 1);
    over_temp = 0; supply_uv = 0;

    // wake abort and resleep from drain
    run_req = 1; step(5); run_req = 0; step(8);
    chk("R2 aborted wake asleep", int'(ldo_en), 0);
    run_req = 1; step(3 + TW + 2);
    run_req = 0; step(4); run_req = 1; step(6);
    chk("R3 drain cancelled", int'(bridge_en), 3);
    step(4);
    model_on = 0;
    summary();
  end
endmodule